// File: doc/BRIEF.md
# March Test Sequencer

The sequencer runs a march test, stored as a short list of gene words, against a memory that is one bit wide and laid out as a grid of rows and columns. Each gene describes one operation and carries a few extra bits. Two marker bits group consecutive genes into march elements. A direction bit and a scan bit on the first gene of an element fix the order in which addresses are visited. A background field turns the gene's data bit into a value for each cell. For every address of an element, all of that element's genes are applied to the cell in order before the sequencer moves to the next address.

Software or a test controller loads the program through a small write port. It then pulses `start`. The sequencer drives a synchronous memory port with one operation per cycle and checks every read one cycle later. It finishes with `done` high. The `fail` flag tells whether any read returned the wrong value. If one did, the outputs hold the row, the column and the gene index of the first mismatch.

Top module: `march_seq`

## Requirements
- R1: Gene bit layout, MSB first: bit 8 starts an element, bit 7 ends an element, bit 6 is the direction, bits 5:4 are the operation, bit 3 is the data bit, bit 2 is the scan order, bits 1:0 are the background. An element also closes before any gene whose bit 8 is set, and at the last store slot. The program ends after an element when the following gene has bit 8 clear or the store is exhausted. If slot 0 has bit 8 clear, the program is empty and issues no memory cycle.
- R2: The sequencer issues exactly one gene per cycle. It applies every gene of the element, in slot order, to one cell before it steps to the next cell. Operation code 1 writes (enable and write-enable high). Code 2 reads (enable high, write-enable low). Codes 0 and 3 are idle and take a cycle with enable low.
- R3: Scan bit 0 visits every column of a row before the next row. Scan bit 1 visits every row of a column before the next column. Row and column outputs always stay inside the grid.
- R4: On an element's first gene, direction 1 starts at row 0, column 0 and ascends. Direction 0 starts at the last row and last column and visits cells in exactly the reverse order.
- R5: The cell value is the data bit XOR a background bit. Background code 0 gives 0. Code 1 gives row LSB XOR column LSB. Code 2 gives the row LSB. Code 3 gives the column LSB. Writes drive this value, and reads expect it.
- R6: Read data is compared in the cycle after the read request. Any mismatch raises `fail`, which stays high until the next accepted start clears it.
- R7: The row, column and gene slot of the first mismatch of a run are captured and are not changed by later mismatches in that run.
- R8: `busy` is high from the cycle after an accepted start through the cycle after the last operation. `done` rises two cycles after the last operation and holds until the next start. Enable is low whenever the sequencer is not running.
- R9: While `busy` is high, a start pulse and writes to the program store are ignored.
- R10: After reset `busy`, `done`, `fail`, the memory enable and the captured fail location are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin execution from slot 0 when idle or done |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | 3 | Program store slot |
| prog_wdata | input | 9 | Gene word to store |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_row | output | 2 | Memory row address |
| mem_col | output | 2 | Memory column address |
| mem_wdata | output | 1 | Write data |
| mem_rdata | input | 1 | Read data, valid the cycle after a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_row | output | 2 | Row of first mismatch |
| fail_col | output | 2 | Column of first mismatch |
| fail_gene | output | 3 | Gene slot of first mismatch |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read request. The rule that the first mismatch follows a read two cycles earlier depends on this. They also assume that `start` and store writes matter only while the sequencer is idle or done. The bench's memory model registers read data on the clock edge that ends the request cycle, so the returned data always has the expected latency. The bench also pulses `start` and writes to the store in the middle of one run, so that the ignore rule is exercised and not just assumed. A stuck cell in the memory model is the only source of mismatches, which makes the expected first-failure location exact.

// File: rtl/march_pkg.sv
// Package: shared gene word layout and code values for the march sequencer.
// Assumes the layout below is the programming format seen at the store port.
package march_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_SPARE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        BG_SOLID   = 2'd0,
        BG_CHECKER = 2'd1,
        BG_ROWALT  = 2'd2,
        BG_COLALT  = 2'd3
    } bg_e;

    // MSB first: open, close, ascend, op[1:0], dbit, walk_col, bg[1:0]
    typedef struct packed {
        logic       open;
        logic       close;
        logic       ascend;
        logic [1:0] op;
        logic       dbit;
        logic       walk_col;
        logic [1:0] bg;
    } gene_t;

    localparam int GENE_W = $bits(gene_t);

endpackage

// File: rtl/march_store.sv
// Module: march_store
// Holds the gene program in flops. It has one write port and two combinational
// read ports: the gene being executed and the header bits of a second slot.
// Assumes the caller gates writes while a run is in progress.
module march_store
    import march_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [GENE_W-1:0] wr_gene,
    input  logic [AW-1:0]     cur_idx,
    input  logic [AW-1:0]     nxt_idx,
    output logic [1:0]        cur_op,
    output logic              cur_dbit,
    output logic [1:0]        cur_bg,
    output logic              cur_close,
    output logic              nxt_open,
    output logic              nxt_ascend,
    output logic              nxt_walk_col
);

    gene_t slots [DEPTH];
    gene_t cur_g;
    gene_t nxt_g;

    // Store update: clear on reset, otherwise accept one gene per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            slots[wr_idx] <= gene_t'(wr_gene);
        end
    end

    // Read ports: out-of-range indices return an empty gene.
    always_comb begin
        cur_g = (int'(cur_idx) < DEPTH) ? slots[cur_idx] : '0;
        nxt_g = (int'(nxt_idx) < DEPTH) ? slots[nxt_idx] : '0;
    end

    assign cur_op       = cur_g.op;
    assign cur_dbit     = cur_g.dbit;
    assign cur_bg       = cur_g.bg;
    assign cur_close    = cur_g.close;
    assign nxt_open     = nxt_g.open;
    assign nxt_ascend   = nxt_g.ascend;
    assign nxt_walk_col = nxt_g.walk_col;

endmodule

// File: rtl/march_addr_gen.sv
// Module: march_addr_gen
// Walks the cell grid in row-major or column-major order, ascending or
// descending. Descending order is the exact reverse of ascending order.
// Assumes init and step are never asserted together.
module march_addr_gen #(
    parameter int ROWS = 3,
    parameter int COLS = 3,
    parameter int RW   = 2,
    parameter int CW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          init_up,
    input  logic          init_walk_col,
    input  logic          step,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output logic          last
);

    localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

    logic          up_q;
    logic          wc_q;
    logic          row_end;
    logic          col_end;
    logic [RW-1:0] row_n;
    logic [CW-1:0] col_n;

    // End-of-line detection for the current direction.
    always_comb begin
        row_end = up_q ? (row == ROW_MAX) : (row == '0);
        col_end = up_q ? (col == COL_MAX) : (col == '0);
        last    = row_end && col_end;
    end

    // Next address: inner index wraps, outer index moves on wrap.
    always_comb begin
        row_n = row;
        col_n = col;
        if (!wc_q) begin
            if (col_end) begin
                col_n = up_q ? '0 : COL_MAX;
                row_n = up_q ? row + RW'(1) : row - RW'(1);
            end else begin
                col_n = up_q ? col + CW'(1) : col - CW'(1);
            end
        end else begin
            if (row_end) begin
                row_n = up_q ? '0 : ROW_MAX;
                col_n = up_q ? col + CW'(1) : col - CW'(1);
            end else begin
                row_n = up_q ? row + RW'(1) : row - RW'(1);
            end
        end
    end

    // Address registers: load the start corner on init, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row  <= '0;
            col  <= '0;
            up_q <= 1'b1;
            wc_q <= 1'b0;
        end else if (init) begin
            up_q <= init_up;
            wc_q <= init_walk_col;
            row  <= init_up ? '0 : ROW_MAX;
            col  <= init_up ? '0 : COL_MAX;
        end else if (step) begin
            row <= row_n;
            col <= col_n;
        end
    end

    assert_in_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(row) < ROWS) && (int'(col) < COLS));

    assert_step_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init && !last) |=> ((row != $past(row)) || (col != $past(col))));

    assert_init_corner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> ($past(init_up) ? (row == '0 && col == '0)
                                 : (row == ROW_MAX && col == COL_MAX)));

endmodule

// File: rtl/march_ctrl.sv
// Module: march_ctrl
// Sequencing FSM: steps through genes, groups them into elements by marker
// bits, drives the memory port, checks reads one cycle later and keeps the
// first failure. Assumes read data returns exactly one cycle after a read.
module march_ctrl
    import march_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int RW    = 2,
    parameter int CW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cur_op,
    input  logic          cur_dbit,
    input  logic [1:0]    cur_bg,
    input  logic          cur_close,
    input  logic          nxt_open,
    input  logic          nxt_ascend,
    input  logic          nxt_walk_col,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    input  logic          addr_last,
    input  logic          mem_rdata,
    output logic [AW-1:0] cur_idx,
    output logic [AW-1:0] nxt_idx,
    output logic          ag_init,
    output logic          ag_up,
    output logic          ag_walk_col,
    output logic          ag_step,
    output logic          mem_en,
    output logic          mem_we,
    output logic          mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [RW-1:0] fail_row,
    output logic [CW-1:0] fail_col,
    output logic [AW-1:0] fail_gene
);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH, S_DONE} state_e;

    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    state_e        state;
    logic [AW-1:0] gptr;
    logic [AW-1:0] estart;
    logic          run;
    logic          accept;
    logic          last_slot;
    logic          elem_end;
    logic          prog_end;
    logic          bg_bit;
    logic          eff;
    logic          is_wr;
    logic          is_rd;
    logic          pend_v;
    logic          pend_exp;
    logic [RW-1:0] pend_row;
    logic [CW-1:0] pend_col;
    logic [AW-1:0] pend_gene;

    // Element and program boundary decode for the gene in flight.
    always_comb begin
        run       = (state == S_RUN);
        accept    = start && (state == S_IDLE || state == S_DONE);
        last_slot = (gptr == LAST_SLOT);
        elem_end  = cur_close || last_slot || nxt_open;
        prog_end  = last_slot || !nxt_open;
        is_wr     = (cur_op == OP_WRITE);
        is_rd     = (cur_op == OP_READ);
    end

    // Background bit for the current cell and the resulting cell value.
    always_comb begin
        unique case (cur_bg)
            BG_SOLID:   bg_bit = 1'b0;
            BG_CHECKER: bg_bit = row[0] ^ col[0];
            BG_ROWALT:  bg_bit = row[0];
            default:    bg_bit = col[0];
        endcase
        eff = cur_dbit ^ bg_bit;
    end

    // Store read indices and address generator controls.
    always_comb begin
        cur_idx     = gptr;
        nxt_idx     = run ? gptr + AW'(1) : '0;
        ag_up       = nxt_ascend;
        ag_walk_col = nxt_walk_col;
        ag_init     = (accept && nxt_open) ||
                      (run && elem_end && addr_last && !prog_end);
        ag_step     = run && elem_end && !addr_last;
    end

    // Memory port and status outputs.
    always_comb begin
        mem_en    = run && (is_wr || is_rd);
        mem_we    = run && is_wr;
        mem_wdata = mem_we ? eff : 1'b0;
        busy      = (state == S_RUN) || (state == S_FLUSH);
        done      = (state == S_DONE);
    end

    // Sequencing: gene pointer, element start and state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            gptr   <= '0;
            estart <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_DONE: begin
                    if (accept) begin
                        gptr   <= '0;
                        estart <= '0;
                        state  <= nxt_open ? S_RUN : S_FLUSH;
                    end
                end
                S_RUN: begin
                    if (!elem_end) begin
                        gptr <= gptr + AW'(1);
                    end else if (!addr_last) begin
                        gptr <= estart;
                    end else if (prog_end) begin
                        state <= S_FLUSH;
                    end else begin
                        gptr   <= gptr + AW'(1);
                        estart <= gptr + AW'(1);
                    end
                end
                default: state <= S_DONE;
            endcase
        end
    end

    // Read pipeline: remember what the returning data must match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_exp  <= 1'b0;
            pend_row  <= '0;
            pend_col  <= '0;
            pend_gene <= '0;
        end else begin
            pend_v    <= run && is_rd;
            pend_exp  <= eff;
            pend_row  <= row;
            pend_col  <= col;
            pend_gene <= gptr;
        end
    end

    // Failure capture: sticky flag and location of the first mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            fail      <= 1'b0;
            fail_row  <= '0;
            fail_col  <= '0;
            fail_gene <= '0;
        end else if (pend_v && (mem_rdata != pend_exp) && !fail) begin
            fail      <= 1'b1;
            fail_row  <= pend_row;
            fail_col  <= pend_col;
            fail_gene <= pend_gene;
        end
    end

    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> fail);

    assert_fail_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(mem_en && !mem_we, 2));

    assert_first_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && $past(fail)) |-> ($stable(fail_row) && $stable(fail_col) && $stable(fail_gene)));

    assert_quiet_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_en && !busy));

    assert_we_has_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state == S_RUN && !(elem_end && addr_last && prog_end)) |=> busy);

endmodule

// File: rtl/march_seq.sv
// Module: march_seq (top)
// March test sequencer: program store, address walker and sequencing FSM.
// Assumes a single-bit synchronous memory whose read data lags one cycle.
module march_seq
    import march_pkg::*;
#(
    parameter int ROWS  = 3,
    parameter int COLS  = 3,
    parameter int DEPTH = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic                                  prog_we,
    input  logic [$clog2(DEPTH)-1:0]              prog_addr,
    input  logic [march_pkg::GENE_W-1:0]          prog_wdata,
    output logic                                  mem_en,
    output logic                                  mem_we,
    output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] mem_row,
    output logic [((COLS > 1) ? $clog2(COLS) : 1)-1:0] mem_col,
    output logic                                  mem_wdata,
    input  logic                                  mem_rdata,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  fail,
    output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] fail_row,
    output logic [((COLS > 1) ? $clog2(COLS) : 1)-1:0] fail_col,
    output logic [$clog2(DEPTH)-1:0]              fail_gene
);

    localparam int AW = $clog2(DEPTH);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

    logic [AW-1:0] cur_idx;
    logic [AW-1:0] nxt_idx;
    logic [1:0]    cur_op;
    logic          cur_dbit;
    logic [1:0]    cur_bg;
    logic          cur_close;
    logic          nxt_open;
    logic          nxt_ascend;
    logic          nxt_walk_col;
    logic          ag_init;
    logic          ag_up;
    logic          ag_walk_col;
    logic          ag_step;
    logic          addr_last;
    logic          store_wr;

    // Store writes are only accepted while no run is in progress.
    assign store_wr = prog_we && !busy;

    march_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (store_wr),
        .wr_idx       (prog_addr),
        .wr_gene      (prog_wdata),
        .cur_idx      (cur_idx),
        .nxt_idx      (nxt_idx),
        .cur_op       (cur_op),
        .cur_dbit     (cur_dbit),
        .cur_bg       (cur_bg),
        .cur_close    (cur_close),
        .nxt_open     (nxt_open),
        .nxt_ascend   (nxt_ascend),
        .nxt_walk_col (nxt_walk_col)
    );

    march_addr_gen #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .init          (ag_init),
        .init_up       (ag_up),
        .init_walk_col (ag_walk_col),
        .step          (ag_step),
        .row           (mem_row),
        .col           (mem_col),
        .last          (addr_last)
    );

    march_ctrl #(.DEPTH(DEPTH), .AW(AW), .RW(RW), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cur_op       (cur_op),
        .cur_dbit     (cur_dbit),
        .cur_bg       (cur_bg),
        .cur_close    (cur_close),
        .nxt_open     (nxt_open),
        .nxt_ascend   (nxt_ascend),
        .nxt_walk_col (nxt_walk_col),
        .row          (mem_row),
        .col          (mem_col),
        .addr_last    (addr_last),
        .mem_rdata    (mem_rdata),
        .cur_idx      (cur_idx),
        .nxt_idx      (nxt_idx),
        .ag_init      (ag_init),
        .ag_up        (ag_up),
        .ag_walk_col  (ag_walk_col),
        .ag_step      (ag_step),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .busy         (busy),
        .done         (done),
        .fail         (fail),
        .fail_row     (fail_row),
        .fail_col     (fail_col),
        .fail_gene    (fail_gene)
    );

endmodule

// File: tb/march_seq_tb.sv
// Scoreboard bench: a driver builds the expected operation stream from the
// requirements into a queue; a monitor pops one entry per cycle and compares.
module march_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS  = 3;
    localparam int COLS  = 3;
    localparam int DEPTH = 8;
    localparam int NCELL = ROWS * COLS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       prog_we = 1'b0;
    logic [2:0] prog_addr = '0;
    logic [8:0] prog_wdata = '0;
    logic       mem_en, mem_we, mem_wdata;
    logic [1:0] mem_row, mem_col;
    logic       mem_rdata = 1'b0;
    logic       busy, done, fail;
    logic [1:0] fail_row, fail_col;
    logic [2:0] fail_gene;

    int nchecks = 0;
    int nfails  = 0;

    logic [8:0] prog [DEPTH];
    logic [NCELL-1:0] mem_cells = '0;
    logic       fault_en = 1'b0;
    int         fault_idx = 0;
    logic       fault_val = 1'b0;

    logic [6:0] expq [$];
    bit         armed = 1'b0;
    int         nops;
    bit         efail;
    int         erow, ecol, egene;

    always #(CLK_PERIOD / 2) clk = ~clk;

    march_seq #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail),
        .fail_row(fail_row), .fail_col(fail_col), .fail_gene(fail_gene)
    );

    // Memory model with an optional stuck cell; read data lags one cycle.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we)
                mem_cells[int'(mem_row) * COLS + int'(mem_col)] <=
                    (fault_en && (int'(mem_row) * COLS + int'(mem_col)) == fault_idx)
                    ? fault_val : mem_wdata;
            else
                mem_rdata <= mem_cells[int'(mem_row) * COLS + int'(mem_col)];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: one expected entry per cycle while a run is armed (R2 R3 R4 R5).
    always @(negedge clk) begin
        if (armed && expq.size() > 0) begin
            logic [6:0] e;
            logic [6:0] g;
            e = expq.pop_front();
            g = {mem_en, mem_we, mem_row, mem_col, mem_we ? mem_wdata : 1'b0};
            chk(g == e, "R2 R3 R4 R5 op stream", int'(g), int'(e));
        end
    end

    function automatic logic [8:0] mk(input bit op_, input bit cl, input bit up,
                                      input int op, input bit d, input bit wc,
                                      input int bg);
        return {op_, cl, up, 2'(op), d, wc, 2'(bg)};
    endfunction

    function automatic bit bgbit(input int bg, input int r, input int c);
        case (bg)
            0: return 1'b0;
            1: return 1'(r ^ c);
            2: return 1'(r);
            default: return 1'(c);
        endcase
    endfunction

    // Reference model of R1..R7, built from the bench copy of the program.
    task automatic build_expect();
        logic [NCELL-1:0] rm;
        int gi;
        bit fin;
        rm = mem_cells;
        nops = 0; efail = 0; erow = 0; ecol = 0; egene = 0;
        expq.delete();
        gi = 0;
        fin = !prog[0][8];
        while (!fin) begin
            int es, ee;
            bit up, wc;
            es = gi; up = prog[es][6]; wc = prog[es][2];
            ee = es;
            while (!(prog[ee][7] || ee == DEPTH - 1)) begin
                if (prog[ee + 1][8]) break;
                ee++;
            end
            for (int k = 0; k < NCELL; k++) begin
                int pos, r, c;
                pos = up ? k : NCELL - 1 - k;
                if (!wc) begin r = pos / COLS; c = pos % COLS; end
                else     begin c = pos / ROWS; r = pos % ROWS; end
                for (int g = es; g <= ee; g++) begin
                    int op;
                    bit v;
                    op = int'(prog[g][5:4]);
                    v = prog[g][3] ^ bgbit(int'(prog[g][1:0]), r & 1, c & 1);
                    if (op == 1) begin
                        rm[r * COLS + c] = (fault_en && (r * COLS + c) == fault_idx) ? fault_val : v;
                        expq.push_back({1'b1, 1'b1, 2'(r), 2'(c), v});
                    end else if (op == 2) begin
                        if (rm[r * COLS + c] != v && !efail) begin
                            efail = 1; erow = r; ecol = c; egene = g;
                        end
                        expq.push_back({1'b1, 1'b0, 2'(r), 2'(c), 1'b0});
                    end else begin
                        expq.push_back({1'b0, 1'b0, 2'(r), 2'(c), 1'b0});
                    end
                    nops++;
                end
            end
            fin = (ee == DEPTH - 1) || !prog[ee + 1][8];
            gi = ee + 1;
        end
    endtask

    task automatic load_prog();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = 3'(i); prog_wdata = prog[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic run_test(input string name, input bit poke);
        int cyc;
        build_expect();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 armed = 1'b1;
        cyc = 0;
        while (cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                // R9: start and store write while busy must have no effect
                start = 1'b1; prog_we = 1'b1; prog_addr = '0; prog_wdata = '1;
            end else begin
                start = 1'b0; prog_we = 1'b0;
            end
            if (done) break;
        end
        armed = 1'b0;
        $display("%s: %0d ops, %0d cycles", name, nops, cyc);
        chk(cyc == nops + 2, "R8 done latency", cyc, nops + 2);
        chk(expq.size() == 0, "R2 all ops issued", expq.size(), 0);
        chk(fail == efail, "R6 fail flag", int'(fail), int'(efail));
        chk(int'(fail_row) == erow, "R7 fail row", int'(fail_row), erow);
        chk(int'(fail_col) == ecol, "R7 fail col", int'(fail_col), ecol);
        chk(int'(fail_gene) == egene, "R7 fail gene", int'(fail_gene), egene);
        repeat (3) @(negedge clk);
        chk(done && !busy && !mem_en, "R8 done held, port quiet", int'({done, busy, mem_en}), 4);
        chk(fail == efail, "R6 fail sticky after done", int'(fail), int'(efail));
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) prog[i] = '0;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(!busy && !done && !fail && !mem_en, "R10 reset flags",
            int'({busy, done, fail, mem_en}), 0);
        chk(fail_row == 0 && fail_col == 0 && fail_gene == 0, "R10 reset fail location",
            int'({fail_row, fail_col, fail_gene}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty program (slot 0 lacks start marker)
        load_prog();
        run_test("R1 empty", 1'b0);

        // R3 R4 R5: solid, row-major ascending, W0 W1 R1
        prog[0] = mk(1, 0, 1, 1, 0, 0, 0);
        prog[1] = mk(0, 0, 0, 1, 1, 0, 0);
        prog[2] = mk(0, 1, 0, 2, 1, 0, 0);
        load_prog();
        run_test("R3 solid ascending", 1'b0);

        // R4 R5 R2 R9: checkerboard, mixed directions and scans, idle gene, poke
        prog[0] = mk(1, 1, 0, 1, 0, 0, 1);
        prog[1] = mk(1, 0, 1, 2, 0, 1, 1);
        prog[2] = mk(0, 1, 0, 1, 1, 0, 1);
        prog[3] = mk(1, 0, 0, 2, 1, 0, 1);
        prog[4] = mk(0, 1, 0, 0, 0, 0, 0);
        load_prog();
        run_test("R4 checkerboard", 1'b1);

        // R1 R3 R5: alternate-row, column-major descending, implicit element close
        for (int i = 0; i < DEPTH; i++) prog[i] = '0;
        prog[0] = mk(1, 0, 0, 1, 1, 1, 2);
        prog[1] = mk(1, 0, 1, 2, 1, 1, 2);
        prog[2] = mk(0, 1, 0, 2, 1, 1, 2);
        load_prog();
        run_test("R1 alt row", 1'b0);

        // R6 R7: alternate-column with stuck-at-1 cell (1,2), two read elements
        for (int i = 0; i < DEPTH; i++) prog[i] = '0;
        prog[0] = mk(1, 1, 1, 1, 0, 0, 3);
        prog[1] = mk(1, 1, 1, 2, 0, 0, 3);
        prog[2] = mk(1, 1, 0, 2, 0, 1, 3);
        fault_en = 1'b1; fault_idx = 1 * COLS + 2; fault_val = 1'b1;
        load_prog();
        run_test("R7 stuck cell", 1'b0);

        // R6: restart without fault clears the flag
        fault_en = 1'b0;
        run_test("R6 restart clean", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        nchecks++;
        nfails++;
        $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

endmodule